// File: doc/BRIEF.md
# Set-Associative Data Cache Access Controller

This block is the control core of a small four-way, sixteen-set data cache with 16-byte lines of four 32-bit words. It holds the tag, valid and dirty arrays, the line storage and an age ordering per set. A CPU request is either a read, a prefetch or a write. The block looks the request up in the cycle it arrives and decides hit or miss. On a miss it picks a victim way and fetches the whole line through a request/acknowledge memory port. A single-word write goes out through the same port. When a victim line is dirty, the block passes that line and its address to an external write-back buffer before the fill begins.

A mode input chooses between write-back and write-through behaviour for each write. A prefetch changes only replacement state on a hit. On a miss it allocates the line and returns no data. A write miss allocates the line in write-back mode and goes straight to memory in write-through mode. The CPU sees a single `ready_o` stall signal. Requests are accepted only while it is high.

Top module: `cache_policy_ctrl`

## Requirements
- R1: After reset `ready_o` is 1 and `rvalid_o`, `mem_req_o` and `wbb_push_o` are 0. A request is accepted on a clock edge where `req_i` and `ready_o` are both 1. `op_i` encodes 2'b00 read, 2'b01 prefetch and 2'b10 write. A read hit raises `rvalid_o` in the next cycle with the addressed word, keeps `ready_o` high and starts no memory cycle.
- R2: Address fields: word select is bits [3:2], set index is bits [7:4] and tag is bits [31:8]. A read miss drops `ready_o` and requests a line fill (`mem_we_o`=0) at the line-aligned address. One acknowledge delivers the whole line on `mem_rline_i`, with word k at bits [32k+31:32k]. `rvalid_o` rises in the cycle after the acknowledge, carrying the requested word.
- R3: A prefetch hit returns no data and starts no memory or buffer activity. It only makes the hit way the most recently used in its set.
- R4: A prefetch miss replaces and fills a line exactly as a read miss does, but never raises `rvalid_o`.
- R5: A write hit with `wb_mode_i`=1 updates the cached word, marks the line dirty and issues no memory cycle.
- R6: A write hit with `wb_mode_i`=0 updates the cached word and issues one memory write (`mem_we_o`=1) of `wdata_i` at the request address.
- R7: A write miss with `wb_mode_i`=1 fills the line, merges the write word into it, and leaves the line valid and dirty.
- R8: A write miss with `wb_mode_i`=0 issues only one memory write and allocates no line.
- R9: The victim is the lowest-numbered invalid way of the set. If all ways are valid, the victim is the least recently used way. Every hit and every fill counts as a use.
- R10: A dirty victim is pushed (`wbb_push_o` for one cycle) with its line address and data before the fill request for the new line starts.
- R11: No push takes place while `wbb_busy_i` is 1. The controller waits with `ready_o` low and no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | CPU request valid |
| op_i | input | 2 | Request kind: read, prefetch, write |
| addr_i | input | 32 | Byte address of the request |
| wdata_i | input | 32 | Write word |
| wb_mode_i | input | 1 | 1 = write-back, 0 = write-through |
| ready_o | output | 1 | Controller idle, request may be accepted |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data |
| mem_req_o | output | 1 | Memory cycle request, held until acknowledge |
| mem_we_o | output | 1 | 1 = single word write, 0 = line fill |
| mem_addr_o | output | 32 | Memory address (line-aligned for fills) |
| mem_wdata_o | output | 32 | Memory write word |
| mem_ack_i | input | 1 | Memory cycle completion |
| mem_rline_i | input | 128 | Fill line, valid with the acknowledge |
| wbb_push_o | output | 1 | Hand a dirty victim to the write-back buffer |
| wbb_addr_o | output | 32 | Line-aligned address of the victim |
| wbb_line_o | output | 128 | Victim line data |
| wbb_busy_i | input | 1 | Write-back buffer cannot take a line |

## Verification
The bench builds one set into a mix of dirty and clean lines, then forces evictions. The evicted line address and contents show whether dirty marking, write merging and age ordering are right: a design that forgot to set the dirty bit on a write hit or a write-back write miss would push nothing, and one that ignored the prefetch hit in its ordering would evict the line that a later read still expects to hit. A write-through write miss is followed by a read to the same line, which must miss; a controller that allocated on it would skip that fill. The busy test holds the buffer busy and checks that neither a push nor a fill request leaks out early.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_PREF  = 2'b01,
    OP_WRITE = 2'b10
  } op_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_EVICT,
    S_FILL,
    S_WRITE
  } state_e;
endpackage

// File: rtl/cpc_hit.sv
module cpc_hit #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 24,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [WAYS-1:0]            valid_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           way_o
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = valid_i[w] && (tags_i[w] == tag_i);
  end

  always_comb begin
    way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) way_o = WAY_W'(w);
    end
  end

  assign hit_o = |match;
endmodule

// File: rtl/cpc_lru.sv
module cpc_lru #(
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  parameter int WAY_W = $clog2(WAYS),
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_set_i,
  input  logic [WAY_W-1:0] touch_way_i,
  input  logic [IDX_W-1:0] rd_set_i,
  input  logic [WAYS-1:0]  valid_i,
  output logic [WAY_W-1:0] victim_o
);
  // age 0 = most recent, WAYS-1 = oldest; ages in a set form a permutation
  logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];
  logic [WAY_W-1:0] age_hit;

  assign age_hit = age_q[touch_set_i][touch_way_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way_i)
          age_q[touch_set_i][w] <= '0;
        else if (age_q[touch_set_i][w] < age_hit)
          age_q[touch_set_i][w] <= age_q[touch_set_i][w] + 1'b1;
      end
    end
  end

  always_comb begin
    logic found;
    found    = 1'b0;
    victim_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!valid_i[w] && !found) begin
        victim_o = WAY_W'(w);
        found    = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (age_q[rd_set_i][w] == WAY_W'(WAYS - 1)) victim_o = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/cache_policy_ctrl.sv
module cache_policy_ctrl
  import cpc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int WAYS       = 4,
  parameter int SETS       = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_i,
  input  logic [1:0]                   op_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [WORD_W-1:0]            wdata_i,
  input  logic                         wb_mode_i,
  output logic                         ready_o,
  output logic                         rvalid_o,
  output logic [WORD_W-1:0]            rdata_o,
  output logic                         mem_req_o,
  output logic                         mem_we_o,
  output logic [ADDR_W-1:0]            mem_addr_o,
  output logic [WORD_W-1:0]            mem_wdata_o,
  input  logic                         mem_ack_i,
  input  logic [WORD_W*LINE_WORDS-1:0] mem_rline_i,
  output logic                         wbb_push_o,
  output logic [ADDR_W-1:0]            wbb_addr_o,
  output logic [WORD_W*LINE_WORDS-1:0] wbb_line_o,
  input  logic                         wbb_busy_i
);
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int BSEL_W = $clog2(WORD_W / 8);
  localparam int OFF_W  = WSEL_W + BSEL_W;
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int WAY_W  = $clog2(WAYS);

  typedef logic [LINE_WORDS-1:0][WORD_W-1:0] line_t;

  line_t                     data_q  [SETS][WAYS];
  logic [WAYS-1:0][TAG_W-1:0] tag_q  [SETS];
  logic [WAYS-1:0]           valid_q [SETS];
  logic [WAYS-1:0]           dirty_q [SETS];

  state_e state_q, state_d;

  logic [ADDR_W-1:0] rq_addr_q;
  logic [WORD_W-1:0] rq_wdata_q;
  logic              rq_wr_q, rq_pf_q;
  logic [WAY_W-1:0]  vic_q;

  // lookup of the incoming request
  logic [IDX_W-1:0]  lk_set;
  logic [TAG_W-1:0]  lk_tag;
  logic [WSEL_W-1:0] lk_word;
  logic              lk_hit;
  logic [WAY_W-1:0]  lk_way, lk_vic;
  logic              is_wr, is_pf, is_rd, accept;

  assign lk_set  = addr_i[OFF_W +: IDX_W];
  assign lk_tag  = addr_i[ADDR_W-1 -: TAG_W];
  assign lk_word = addr_i[BSEL_W +: WSEL_W];
  assign is_wr   = (op_i == OP_WRITE);
  assign is_pf   = (op_i == OP_PREF);
  assign is_rd   = !is_wr && !is_pf;
  assign accept  = (state_q == S_IDLE) && req_i;

  // pending request fields
  logic [IDX_W-1:0]  rq_set;
  logic [TAG_W-1:0]  rq_tag;
  logic [WSEL_W-1:0] rq_word;
  assign rq_set  = rq_addr_q[OFF_W +: IDX_W];
  assign rq_tag  = rq_addr_q[ADDR_W-1 -: TAG_W];
  assign rq_word = rq_addr_q[BSEL_W +: WSEL_W];

  cpc_hit #(.WAYS(WAYS), .TAG_W(TAG_W)) u_hit (
    .tags_i (tag_q[lk_set]),
    .valid_i(valid_q[lk_set]),
    .tag_i  (lk_tag),
    .hit_o  (lk_hit),
    .way_o  (lk_way)
  );

  logic             fill_done, lru_touch;
  logic [IDX_W-1:0] lru_set;
  logic [WAY_W-1:0] lru_way;
  assign fill_done = (state_q == S_FILL) && mem_ack_i;
  assign lru_touch = (accept && lk_hit) || fill_done;
  assign lru_set   = fill_done ? rq_set : lk_set;
  assign lru_way   = fill_done ? vic_q : lk_way;

  cpc_lru #(.WAYS(WAYS), .SETS(SETS)) u_lru (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .touch_i    (lru_touch),
    .touch_set_i(lru_set),
    .touch_way_i(lru_way),
    .rd_set_i   (lk_set),
    .valid_i    (valid_q[lk_set]),
    .victim_o   (lk_vic)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (accept) begin
        if (is_wr && !wb_mode_i)        state_d = lk_hit ? S_WRITE : S_WRITE;
        else if (lk_hit)                state_d = S_IDLE;
        else if (dirty_q[lk_set][lk_vic]) state_d = S_EVICT;
        else                            state_d = S_FILL;
      end
      S_EVICT: if (!wbb_busy_i) state_d = S_FILL;
      S_FILL:  if (mem_ack_i)   state_d = S_IDLE;
      S_WRITE: if (mem_ack_i)   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  line_t fill_line;
  always_comb begin
    fill_line = mem_rline_i;
    if (rq_wr_q) fill_line[rq_word] = rq_wdata_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      rq_addr_q  <= '0;
      rq_wdata_q <= '0;
      rq_wr_q    <= 1'b0;
      rq_pf_q    <= 1'b0;
      vic_q      <= '0;
      rvalid_o   <= 1'b0;
      rdata_o    <= '0;
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else begin
      state_q  <= state_d;
      rvalid_o <= 1'b0;
      if (accept) begin
        rq_addr_q  <= addr_i;
        rq_wdata_q <= wdata_i;
        rq_wr_q    <= is_wr;
        rq_pf_q    <= is_pf;
        vic_q      <= lk_vic;
        if (lk_hit && is_rd) begin
          rvalid_o <= 1'b1;
          rdata_o  <= data_q[lk_set][lk_way][lk_word];
        end
        if (lk_hit && is_wr && wb_mode_i) dirty_q[lk_set][lk_way] <= 1'b1;
      end
      if (wbb_push_o) dirty_q[rq_set][vic_q] <= 1'b0;
      if (fill_done) begin
        valid_q[rq_set][vic_q] <= 1'b1;
        dirty_q[rq_set][vic_q] <= rq_wr_q;
        if (!rq_wr_q && !rq_pf_q) begin
          rvalid_o <= 1'b1;
          rdata_o  <= fill_line[rq_word];
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (accept && lk_hit && is_wr) data_q[lk_set][lk_way][lk_word] <= wdata_i;
    if (fill_done) begin
      data_q[rq_set][vic_q] <= fill_line;
      tag_q[rq_set][vic_q]  <= rq_tag;
    end
  end

  assign ready_o     = (state_q == S_IDLE);
  assign mem_req_o   = (state_q == S_FILL) || (state_q == S_WRITE);
  assign mem_we_o    = (state_q == S_WRITE);
  assign mem_addr_o  = mem_we_o ? rq_addr_q : {rq_addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_wdata_o = rq_wdata_q;
  assign wbb_push_o  = (state_q == S_EVICT) && !wbb_busy_i;
  assign wbb_addr_o  = {tag_q[rq_set][vic_q], rq_set, {OFF_W{1'b0}}};
  assign wbb_line_o  = data_q[rq_set][vic_q];
endmodule

// File: rtl/cpc_checker.sv
module cpc_checker
  import cpc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [1:0]        op_i,
  input logic              wb_mode_i,
  input logic              ready_o,
  input logic              rvalid_o,
  input logic              mem_req_o,
  input logic              mem_ack_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              wbb_push_o,
  input logic              wbb_busy_i,
  input logic              lk_hit
);
  logic acc;
  assign acc = req_i && ready_o;

  // R1: read hit answers in the next cycle
  a_r1_hit_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && op_i == OP_READ && lk_hit |=> rvalid_o && ready_o);

  // R2: memory request held steady until acknowledged
  a_r2_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));

  // R3/R4: a prefetch never returns data
  a_r3_pref_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && op_i == OP_PREF |=> !rvalid_o);

  // R5: write-back hit stays inside the cache
  a_r5_wb_hit_local: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && op_i == OP_WRITE && wb_mode_i && lk_hit |=> !mem_req_o && ready_o);

  // R10: push and fill never overlap
  a_r10_push_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wbb_push_o |-> !mem_req_o && !ready_o);

  // R11: no push into a busy buffer
  a_r11_no_push_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wbb_push_o |-> !wbb_busy_i);
endmodule

bind cache_policy_ctrl cpc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .op_i      (op_i),
  .wb_mode_i (wb_mode_i),
  .ready_o   (ready_o),
  .rvalid_o  (rvalid_o),
  .mem_req_o (mem_req_o),
  .mem_ack_i (mem_ack_i),
  .mem_addr_o(mem_addr_o),
  .wbb_push_o(wbb_push_o),
  .wbb_busy_i(wbb_busy_i),
  .lk_hit    (lk_hit)
);

// File: tb/cache_policy_ctrl_tb.sv
module cache_policy_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0, rst_n = 1'b0;
  logic         req = 1'b0, wb_mode = 1'b1, wbb_busy = 1'b0;
  logic [1:0]   op = 2'b00;
  logic [31:0]  addr = '0, wdata = '0;
  logic         ready, rvalid, mem_req, mem_we, mem_ack, wbb_push;
  logic [31:0]  rdata, mem_addr, mem_wdata, wbb_addr;
  logic [127:0] mem_rline, wbb_line;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_policy_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .addr_i(addr),
    .wdata_i(wdata), .wb_mode_i(wb_mode), .ready_o(ready), .rvalid_o(rvalid),
    .rdata_o(rdata), .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rline_i(mem_rline),
    .wbb_push_o(wbb_push), .wbb_addr_o(wbb_addr), .wbb_line_o(wbb_line),
    .wbb_busy_i(wbb_busy)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [127:0] mem_line(input logic [31:0] a);
    logic [127:0] l;
    for (int k = 0; k < 4; k++) l[32*k +: 32] = mem_word({a[31:4], 2'(k), 2'b00});
    return l;
  endfunction

  // memory model: acknowledge three cycles after request
  int unsigned n_fill = 0, n_wr = 0, n_rv = 0, n_push = 0, cyc = 0;
  int unsigned push_cyc = 0, fill_cyc = 0;
  logic [31:0]  last_waddr = '0, last_wdata = '0, last_rd = '0, push_addr = '0;
  logic [127:0] push_line = '0;
  logic [1:0]   lat = '0;
  logic         req_d = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; lat <= '0; mem_rline <= '0;
    end else if (mem_req && !mem_ack) begin
      if (lat == 2'd2) begin
        mem_ack <= 1'b1; lat <= '0;
        mem_rline <= mem_line(mem_addr);
        if (mem_we) begin
          n_wr <= n_wr + 1; last_waddr <= mem_addr; last_wdata <= mem_wdata;
        end else n_fill <= n_fill + 1;
      end else lat <= lat + 1'b1;
    end else mem_ack <= 1'b0;
  end

  always @(posedge clk) begin
    cyc   <= cyc + 1;
    req_d <= mem_req;
    if (rst_n) begin
      if (rvalid) begin n_rv <= n_rv + 1; last_rd <= rdata; end
      if (wbb_push) begin
        n_push <= n_push + 1; push_addr <= wbb_addr; push_line <= wbb_line; push_cyc <= cyc;
      end
      if (mem_req && !mem_we && !req_d) fill_cyc <= cyc;
    end
  end

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] o, input logic [31:0] a, input logic [31:0] d, input logic m);
    @(negedge clk);
    req = 1'b1; op = o; addr = a; wdata = d; wb_mode = m;
    while (!ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    while (!ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic        mode;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic        rv;
    logic        from_mem;
    logic [1:0]  dfill;
    logic [1:0]  dwr;
  } vec_t;

  // set 1 is filled ways 0..3 in order (R9), then aged so way 0 is oldest
  localparam vec_t VECS [13] = '{
    '{2'b00, 1'b1, 32'h0000_0114, 32'h0,           1'b1, 1'b1, 2'd1, 2'd0}, // R2 read miss
    '{2'b00, 1'b1, 32'h0000_011C, 32'h0,           1'b1, 1'b1, 2'd0, 2'd0}, // R1 read hit
    '{2'b01, 1'b1, 32'h0000_0210, 32'h0,           1'b0, 1'b0, 2'd1, 2'd0}, // R4 prefetch miss
    '{2'b00, 1'b1, 32'h0000_0218, 32'h0,           1'b1, 1'b1, 2'd0, 2'd0}, // R4 line present
    '{2'b10, 1'b1, 32'h0000_0118, 32'hDEAD_BEEF,   1'b0, 1'b0, 2'd0, 2'd0}, // R5 wb hit
    '{2'b00, 1'b1, 32'h0000_0118, 32'hDEAD_BEEF,   1'b1, 1'b0, 2'd0, 2'd0}, // R5 data kept
    '{2'b10, 1'b0, 32'h0000_0214, 32'h1234_5678,   1'b0, 1'b0, 2'd0, 2'd1}, // R6 wt hit
    '{2'b00, 1'b1, 32'h0000_0214, 32'h1234_5678,   1'b1, 1'b0, 2'd0, 2'd0}, // R6 cache updated
    '{2'b10, 1'b0, 32'h0000_0310, 32'h0BAD_F00D,   1'b0, 1'b0, 2'd0, 2'd1}, // R8 wt miss
    '{2'b00, 1'b1, 32'h0000_0314, 32'h0,           1'b1, 1'b1, 2'd1, 2'd0}, // R8 not allocated
    '{2'b10, 1'b1, 32'h0000_0410, 32'hCAFE_F00D,   1'b0, 1'b0, 2'd1, 2'd0}, // R7 wb miss
    '{2'b00, 1'b1, 32'h0000_0410, 32'hCAFE_F00D,   1'b1, 1'b0, 2'd0, 2'd0}, // R7 merged
    '{2'b00, 1'b1, 32'h0000_0414, 32'h0,           1'b1, 1'b1, 2'd0, 2'd0}  // R7 rest of line
  };

  initial begin
    int unsigned f0, w0, r0, p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1,    "R1 reset ready", 128'(ready), 128'd1);
    chk(rvalid == 1'b0,   "R1 reset rvalid", 128'(rvalid), 128'd0);
    chk(mem_req == 1'b0,  "R1 reset mem_req", 128'(mem_req), 128'd0);
    chk(wbb_push == 1'b0, "R1 reset push", 128'(wbb_push), 128'd0);

    for (int i = 0; i < 13; i++) begin
      vec_t v;
      logic [31:0] exp_d;
      v = VECS[i];
      f0 = n_fill; w0 = n_wr; r0 = n_rv; p0 = n_push;
      access(v.op, v.addr, v.wdata, v.mode);
      exp_d = v.from_mem ? mem_word(v.addr) : v.wdata;
      chk(n_fill - f0 == 32'(v.dfill), $sformatf("vec%0d fills", i), 128'(n_fill - f0), 128'(v.dfill));
      chk(n_wr - w0 == 32'(v.dwr), $sformatf("vec%0d writes", i), 128'(n_wr - w0), 128'(v.dwr));
      chk(n_rv - r0 == 32'(v.rv), $sformatf("vec%0d rvalid", i), 128'(n_rv - r0), 128'(v.rv));
      chk(n_push == p0, $sformatf("vec%0d pushes", i), 128'(n_push - p0), 128'd0);
      if (v.rv) chk(last_rd == exp_d, $sformatf("vec%0d rdata", i), 128'(last_rd), 128'(exp_d));
      if (v.dwr != 0) begin
        chk(last_waddr == v.addr, $sformatf("vec%0d waddr", i), 128'(last_waddr), 128'(v.addr));
        chk(last_wdata == v.wdata, $sformatf("vec%0d wdata", i), 128'(last_wdata), 128'(v.wdata));
      end
    end

    // R11/R10: way 0 of set 1 (line 0x110, dirty) is the victim; buffer busy first
    f0 = n_fill; p0 = n_push;
    wbb_busy = 1'b1;
    @(negedge clk);
    req = 1'b1; op = 2'b00; addr = 32'h0000_0510; wb_mode = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    repeat (6) @(negedge clk);
    chk(n_push == p0, "R11 no push while busy", 128'(n_push - p0), 128'd0);
    chk(mem_req == 1'b0, "R11 no fill while busy", 128'(mem_req), 128'd0);
    chk(ready == 1'b0, "R11 stalled", 128'(ready), 128'd0);
    wbb_busy = 1'b0;
    while (!ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    chk(n_push - p0 == 1, "R10 one push", 128'(n_push - p0), 128'd1);
    chk(push_addr == 32'h0000_0110, "R10 push addr", 128'(push_addr), 128'h110);
    chk(push_line == {mem_word(32'h11C), 32'hDEAD_BEEF, mem_word(32'h114), mem_word(32'h110)},
        "R10 push line (R5 dirty)", push_line,
        {mem_word(32'h11C), 32'hDEAD_BEEF, mem_word(32'h114), mem_word(32'h110)});
    chk(fill_cyc > push_cyc, "R10 push before fill", 128'(fill_cyc), 128'(push_cyc));
    chk(n_fill - f0 == 1, "R2 fill after evict", 128'(n_fill - f0), 128'd1);
    chk(last_rd == mem_word(32'h510), "R2 rdata after evict", 128'(last_rd), 128'(mem_word(32'h510)));

    // R3: prefetch hit on way 1 (line 0x210) makes it newest; way 2 becomes oldest
    f0 = n_fill; r0 = n_rv; p0 = n_push;
    access(2'b01, 32'h0000_0210, 32'h0, 1'b1);
    chk(n_fill == f0 && n_push == p0, "R3 prefetch hit no traffic", 128'(n_fill - f0), 128'd0);
    chk(n_rv == r0, "R3 prefetch hit no data", 128'(n_rv - r0), 128'd0);

    // R9: clean oldest way 2 is replaced, no push
    f0 = n_fill; p0 = n_push;
    access(2'b00, 32'h0000_0610, 32'h0, 1'b1);
    chk(n_fill - f0 == 1 && n_push == p0, "R9 clean lru victim", 128'(n_push - p0), 128'd0);
    chk(last_rd == mem_word(32'h610), "R9 rdata", 128'(last_rd), 128'(mem_word(32'h610)));

    f0 = n_fill;
    access(2'b00, 32'h0000_0218, 32'h0, 1'b1);
    chk(n_fill == f0, "R3 prefetched line survived", 128'(n_fill - f0), 128'd0);
    chk(last_rd == mem_word(32'h218), "R3 rdata", 128'(last_rd), 128'(mem_word(32'h218)));

    // R7: oldest is now way 3 (line 0x410, dirty from write miss)
    p0 = n_push;
    access(2'b00, 32'h0000_0710, 32'h0, 1'b1);
    chk(n_push - p0 == 1, "R7 write-miss line dirty", 128'(n_push - p0), 128'd1);
    chk(push_addr == 32'h0000_0410, "R7 push addr", 128'(push_addr), 128'h410);
    chk(push_line == {mem_word(32'h41C), mem_word(32'h418), mem_word(32'h414), 32'hCAFE_F00D},
        "R7 merged line", push_line,
        {mem_word(32'h41C), mem_word(32'h418), mem_word(32'h414), 32'hCAFE_F00D});
    chk(last_rd == mem_word(32'h710), "R2 rdata", 128'(last_rd), 128'(mem_word(32'h710)));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule